// File: doc/BRIEF.md
# Modem Line Status Register with Change Flags

This block watches four active-low modem handshake inputs: clear-to-send, data-set-ready, ring indicator and carrier detect. It presents them to a CPU as one 8-bit read-only register. The upper nibble shows the present state of each line, inverted so that an asserted (low) pin reads as 1. The lower nibble holds sticky change flags. A flag is set when its line changes and is cleared by a register read. The ring-indicator flag is the exception: it records only the trailing edge of a ring, that is, the pin going from low back to high.

External pins are synchronized before any edge detection. A loopback input replaces the four pins with four internal control bits, so the host can drive the status logic without external wiring. In loopback, changes in those control bits raise change flags in the same way as pin changes. An interrupt request is raised while any change flag is set and the interrupt is enabled. The read strobe comes from an address decode outside this block. Read data is combinational and shows the flags as they stood before the read clears them.

Top module: `modem_status`

## Requirements
- R1: After reset is released with steady inputs, no change flag is ever set. While reset is asserted, rd_data_o[3:0] is 0 and irq_o is 0.
- R2: With loopback off, rd_data_o bits 4, 5, 6 and 7 equal the complements of cts_n_i, dsr_n_i, ri_n_i and dcd_n_i respectively. Each bit reflects its pin no later than the third clock edge after the pin changes.
- R3: Bits 0 (clear-to-send), 1 (data-set-ready) and 3 (carrier detect) are set when their effective status bit (bits 4, 5 and 7) changes in either direction.
- R4: Bit 2 is set only when the effective ring status (bit 6) goes from 1 to 0, which in pin mode is ri_n_i going from low to high. A 0-to-1 change of bit 6 leaves bit 2 clear.
- R5: A set change flag stays set for as long as no read strobe occurs.
- R6: A cycle with rd_stb_i high returns the flags as they were before the read, and clears all four flags at the following edge.
- R7: If a flag-setting change and a read fall in the same cycle, the read returns the old flag value and the flag is set after that edge.
- R8: With loop_en_i high, bits 4, 5, 6 and 7 read loop_rts_i, loop_dtr_i, loop_aux1_i and loop_aux2_i directly, without inversion.
- R9: In loopback, changes of the control bits set the change flags under the rules of R3 and R4, one clock edge after the change.
- R10: irq_o is 1 exactly when irq_en_i is 1 and at least one of rd_data_o[3:0] is 1. While enabled, it stays asserted until a read.
- R11: In loopback, changes on the four external pins alter neither the status bits nor the change flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n_i | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n_i | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_n_i | input | 1 | Carrier detect pin, active low, asynchronous |
| loop_en_i | input | 1 | Loopback select |
| loop_rts_i | input | 1 | Control bit looped to clear-to-send status |
| loop_dtr_i | input | 1 | Control bit looped to data-set-ready status |
| loop_aux1_i | input | 1 | Control bit looped to ring status |
| loop_aux2_i | input | 1 | Control bit looped to carrier status |
| irq_en_i | input | 1 | Modem-status interrupt enable |
| rd_stb_i | input | 1 | Single-cycle read strobe, already address-qualified |
| rd_data_o | output | 8 | Register contents: status in 7..4, change flags in 3..0 |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
Assertions check several properties on every cycle. Flags hold without a read. A read with no new change empties them. A change of either direction on the non-ring lines sets its flag. A newly set ring flag always follows a 1-to-0 ring status. No flag appears during the post-reset priming window. An enabled interrupt is held until read. Other behaviour needs scenarios from the bench. These are the exact bit mapping through the pin inversion and the loopback mux, the synchronizer latency, the read returning pre-clear values when a change coincides with it, and pins being ignored in loopback. The bench covers them by sweeping every pair of 4-bit line patterns in both modes.

// File: rtl/modem_stat_pkg.sv
package modem_stat_pkg;
  localparam int unsigned LINES    = 4;
  localparam int unsigned IDX_CTS  = 0;
  localparam int unsigned IDX_DSR  = 1;
  localparam int unsigned IDX_RI   = 2;
  localparam int unsigned IDX_DCD  = 3;
  localparam int unsigned SYNC_STG = 2;

  typedef logic [LINES-1:0] line_vec_t;

  typedef struct packed {
    line_vec_t stat;
    line_vec_t delta;
  } msr_word_t;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (g == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stage_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= RST_VAL;
      else         stage_q[g] <= src;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/msr_src_mux.sv
module msr_src_mux #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] pin_n_i,
  input  logic [WIDTH-1:0] ctrl_i,
  input  logic             loop_i,
  output logic [WIDTH-1:0] stat_o
);
  // status is active high; pins are active low
  always_comb begin
    stat_o = loop_i ? ctrl_i : ~pin_n_i;
  end
endmodule

// File: rtl/msr_delta.sv
module msr_delta #(
  parameter int unsigned WIDTH     = 4,
  parameter int unsigned TRAIL_IDX = 2,
  parameter int unsigned PRIME     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] stat_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] delta_o
);
  localparam int unsigned CNT_W = $clog2(PRIME + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             primed;
  logic [WIDTH-1:0] hist_q, delta_q, set_w;

  assign primed = (cnt_q == CNT_W'(PRIME));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!primed) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= stat_i;
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_edge
    if (g == TRAIL_IDX) begin : g_trail
      // status 1->0 only (pin low->high)
      assign set_w[g] = primed & hist_q[g] & ~stat_i[g];
    end else begin : g_any
      assign set_w[g] = primed & (hist_q[g] ^ stat_i[g]);

      // R3
      any_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        primed && (stat_i[g] != hist_q[g]) |=> delta_q[g]);
    end
  end

  // read clears; a simultaneous set wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) delta_q <= '0;
    else         delta_q <= (delta_q & ~{WIDTH{rd_i}}) | set_w;
  end

  assign delta_o = delta_q;

  // R5
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (delta_q & $past(delta_q)) == $past(delta_q));

  // R6
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && (set_w == '0) |=> delta_q == '0);

  // R4
  trail_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(delta_q[TRAIL_IDX]) |-> $past(hist_q[TRAIL_IDX]) && !$past(stat_i[TRAIL_IDX]));

  // R1
  prime_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed |=> delta_q == '0);
endmodule

// File: rtl/modem_status.sv
module modem_status
  import modem_stat_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cts_n_i,
  input  logic       dsr_n_i,
  input  logic       ri_n_i,
  input  logic       dcd_n_i,
  input  logic       loop_en_i,
  input  logic       loop_rts_i,
  input  logic       loop_dtr_i,
  input  logic       loop_aux1_i,
  input  logic       loop_aux2_i,
  input  logic       irq_en_i,
  input  logic       rd_stb_i,
  output logic [7:0] rd_data_o,
  output logic       irq_o
);
  localparam int unsigned PRIME = SYNC_STG + 1;

  line_vec_t pin_n, pin_sync_n, ctrl, stat_w, delta_w;
  msr_word_t word;

  always_comb begin
    pin_n          = '1;
    pin_n[IDX_CTS] = cts_n_i;
    pin_n[IDX_DSR] = dsr_n_i;
    pin_n[IDX_RI]  = ri_n_i;
    pin_n[IDX_DCD] = dcd_n_i;
    ctrl           = '0;
    ctrl[IDX_CTS]  = loop_rts_i;
    ctrl[IDX_DSR]  = loop_dtr_i;
    ctrl[IDX_RI]   = loop_aux1_i;
    ctrl[IDX_DCD]  = loop_aux2_i;
  end

  msr_sync #(.WIDTH(LINES), .STAGES(SYNC_STG), .RST_VAL('1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_n),
    .q_o   (pin_sync_n)
  );

  msr_src_mux #(.WIDTH(LINES)) i_mux (
    .pin_n_i(pin_sync_n),
    .ctrl_i (ctrl),
    .loop_i (loop_en_i),
    .stat_o (stat_w)
  );

  msr_delta #(.WIDTH(LINES), .TRAIL_IDX(IDX_RI), .PRIME(PRIME)) i_delta (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stat_i (stat_w),
    .rd_i   (rd_stb_i),
    .delta_o(delta_w)
  );

  assign word.stat  = stat_w;
  assign word.delta = delta_w;
  assign rd_data_o  = word;
  assign irq_o      = irq_en_i & (|delta_w);

  // R10
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !rd_stb_i |=> irq_o || !irq_en_i);

  // R10
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_en_i && (rd_data_o[3:0] != 4'h0));
endmodule

// File: tb/test_modem_status.sv
module test_modem_status;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic       loop_en = 1'b0, l_rts = 1'b0, l_dtr = 1'b0, l_a1 = 1'b0, l_a2 = 1'b0;
  logic       irq_en = 1'b0, rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic       irq;
  int         n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  modem_status i_modem_status (
    .clk_i(clk), .rst_ni(rst_ni),
    .cts_n_i(cts_n), .dsr_n_i(dsr_n), .ri_n_i(ri_n), .dcd_n_i(dcd_n),
    .loop_en_i(loop_en), .loop_rts_i(l_rts), .loop_dtr_i(l_dtr),
    .loop_aux1_i(l_a1), .loop_aux2_i(l_a2),
    .irq_en_i(irq_en), .rd_stb_i(rd_stb),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // p[0]=cts, p[1]=dsr, p[2]=ri, p[3]=dcd pin levels
  task automatic set_pins(input logic [3:0] p);
    {dcd_n, ri_n, dsr_n, cts_n} = p;
  endtask

  task automatic set_ctrl(input logic [3:0] c);
    {l_a2, l_a1, l_dtr, l_rts} = c;
  endtask

  task automatic rd_clear();
    rd_stb = 1'b1;
    tick(1);
    rd_stb = 1'b0;
  endtask

  task automatic sample_read(output logic [7:0] v);
    rd_stb = 1'b1;
    #1 v = rd_data;
    tick(1);
    rd_stb = 1'b0;
  endtask

  // expected flags for a status change a -> b
  function automatic logic [3:0] exp_delta(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] d;
    d    = a ^ b;
    d[2] = a[2] & ~b[2];
    return d;
  endfunction

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [3:0] d;
    irq_en = 1'b1;
    tick(2);

    // R1: reset state and quiet priming, all pin patterns
    for (int p = 0; p < 16; p++) begin
      set_pins(4'(p));
      rst_ni = 1'b0;
      tick(1);
      #1 chk("R1 in reset", {irq, 3'b0, rd_data[3:0]}, 8'h00);
      rst_ni = 1'b1;
      tick(6);
      chk("R1 after reset", {irq, rd_data}, {1'b0, ~4'(p), 4'h0});
    end
    // R1: reset in loopback with nonzero control
    loop_en = 1'b1;
    set_ctrl(4'hB);
    rst_ni = 1'b0;
    tick(1);
    rst_ni = 1'b1;
    tick(6);
    chk("R1 loop reset", rd_data, 8'hB0);
    loop_en = 1'b0;
    tick(4);
    rd_clear();

    // pin mode sweep over all pattern pairs
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        set_pins(4'(a));
        tick(4);
        rd_clear();
        chk("R2 status", rd_data, {~4'(a), 4'h0});
        irq_en = ((a + b) % 2) == 0;
        set_pins(4'(b));
        tick(4);
        d = exp_delta(~4'(a), ~4'(b));
        chk("R3/R4 pin flags", rd_data, {~4'(b), d});
        chk("R10 irq", {7'b0, irq}, {7'b0, irq_en && (d != 4'h0)});
        tick(5);
        chk("R5 sticky", rd_data, {~4'(b), d});
        sample_read(v);
        chk("R6 pre-clear read", v, {~4'(b), d});
        chk("R6 cleared", rd_data, {~4'(b), 4'h0});
      end
    end
    irq_en = 1'b1;

    // R7 pin mode: change reaches status in the read cycle
    set_pins(4'hF);
    tick(4);
    rd_clear();
    set_pins(4'hE);
    tick(2);
    rd_stb = 1'b1;
    #1 chk("R7 pin read old", rd_data, 8'h10);
    tick(1);
    rd_stb = 1'b0;
    #1 chk("R7 pin flag kept", rd_data, 8'h11);
    tick(1);
    rd_clear();

    // loopback sweep; pins held to the opposite polarity
    loop_en = 1'b1;
    set_pins(4'h0);
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        set_ctrl(4'(a));
        tick(1);
        rd_clear();
        chk("R8 loop status", rd_data, {4'(a), 4'h0});
        set_ctrl(4'(b));
        tick(1);
        chk("R9 loop flags", rd_data, {4'(b), exp_delta(4'(a), 4'(b))});
        sample_read(v);
        chk("R6 loop cleared", rd_data[7:0], {4'(b), 4'h0});
      end
    end

    // R11: pins ignored in loopback
    set_ctrl(4'h5);
    tick(1);
    rd_clear();
    for (int p = 0; p < 16; p++) begin
      set_pins(4'(p));
      tick(4);
      chk("R11 pins ignored", rd_data, 8'h50);
    end

    // R7 loopback: change and read in the same cycle
    set_ctrl(4'h0);
    tick(1);
    rd_clear();
    set_ctrl(4'h1);
    rd_stb = 1'b1;
    #1 chk("R7 loop read old", rd_data, 8'h10);
    tick(1);
    rd_stb = 1'b0;
    #1 chk("R7 loop flag kept", rd_data, 8'h11);

    // R10: enable gating with a pending flag
    irq_en = 1'b0;
    #1 chk("R10 disabled", {7'b0, irq}, 8'h00);
    irq_en = 1'b1;
    #1 chk("R10 enabled", {7'b0, irq}, 8'h01);
    tick(3);
    chk("R10 held", {7'b0, irq}, 8'h01);
    rd_clear();
    chk("R10 after read", {7'b0, irq}, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule